// File: doc/BRIEF.md
# Undefined-Length Burst End Predictor

This block watches the transfer stream on one slave port of a bus matrix. It produces two single-cycle flags that the slave's arbiter uses to decide when it may hand the port to another master. The first flag, `pred_end`, marks a beat that closes a burst. For defined-length bursts this is the real last beat, taken from the beat count. For incrementing bursts of unspecified length, a programmable mode decides how the burst is cut. It can run unbroken, or be split into virtual bursts of one beat or of four beats.

The second flag, `slot_reached`, comes from a slot cycle counter. It fires when the current master has held the port for a programmed number of cycles. This lets arbitration happen before any burst completes, whatever its type. Both flags are combinational on the current transfer, computed from registered beat and slot counts. Both are valid in the cycle the transfer is presented. The arbiter itself and all data handling are outside this block.

Top module: `burst_end_predictor`

## Requirements
- R1: After reset both counts are zero, so a SEQ beat presented before any NONSEQ counts as beat 1 and slot cycle 1.
- R2: A transfer is a beat when `tr_valid` is 1 and `tr_kind` is NONSEQ (2) or SEQ (3). IDLE is 0 and BUSY is 1. For `burst_kind` 0 (single), `pred_end` is 1 on every beat.
- R3: For `burst_kind` 2/3 (4 beats), 4/5 (8 beats) or 6/7 (16 beats), in wrapping or incrementing form, `pred_end` is 1 only on the beat whose index equals the length. The index is 1 on NONSEQ and previous+1 on SEQ, and is kept modulo 32.
- R4: For `burst_kind` 1 (incrementing, unspecified length), when `undef_mode` is 0 (unlimited, the reset default setting) or 3 (treated as unlimited), `pred_end` is never 1.
- R5: For `burst_kind` 1 with `undef_mode` 1, `pred_end` is 1 on every beat.
- R6: For `burst_kind` 1 with `undef_mode` 2, `pred_end` is 1 on beats whose index is a multiple of 4.
- R7: A valid BUSY cycle neither advances the beat index nor raises `pred_end`. It does count as a slot cycle.
- R8: A valid NONSEQ restarts both the beat index and the slot count at 1. A valid IDLE clears both counts to 0.
- R9: With a non-zero `slot_limit`, `slot_reached` is 1 in the one valid non-IDLE cycle whose slot index equals `slot_limit`. The slot index is 1 on NONSEQ and previous+1 on SEQ or BUSY, and saturates above any limit. After that cycle it stays 0 until the next NONSEQ.
- R10: A `slot_limit` of 0 keeps `slot_reached` at 0.
- R11: While `tr_valid` is 0, both outputs are 0 and both counts hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tr_valid | input | 1 | Transfer presented and accepted this cycle |
| tr_kind | input | 2 | Transfer type: 0 idle, 1 busy, 2 nonseq, 3 seq |
| burst_kind | input | 3 | Burst type code (0 single, 1 undefined incr, 2..7 wrap/incr 4, 8, 16) |
| undef_mode | input | 2 | Splitting mode for undefined-length bursts |
| slot_limit | input | SLOT_W | Slot cycle limit, 0 disables |
| pred_end | output | 1 | Predicted end of burst on this beat |
| slot_reached | output | 1 | Slot cycle limit reached in this cycle |

## Verification
The two flags can rise in the same cycle when a burst's own end and the slot limit land on the same beat. For example, a 4-beat burst or a 4-beat-split undefined burst with a slot limit of 4 and no busy cycles hits both on beat 4. A directed case builds exactly that and expects both flags together. The random bursts also produce such overlaps, with limits drawn from a small range and busy cycles that move the slot count relative to the beat count. A bench model computes each flag on its own, and each flag is compared independently in every cycle.

// File: rtl/burst_end_predictor.sv
module burst_end_predictor #(
  parameter int SLOT_W = 8,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_valid,
  input  logic [1:0]        tr_kind,
  input  logic [2:0]        burst_kind,
  input  logic [1:0]        undef_mode,
  input  logic [SLOT_W-1:0] slot_limit,
  output logic              pred_end,
  output logic              slot_reached
);
  localparam logic [1:0] K_IDLE = 2'd0;
  localparam logic [1:0] K_BUSY = 2'd1;
  localparam logic [1:0] K_NSEQ = 2'd2;
  localparam logic [1:0] K_SEQ  = 2'd3;
  localparam logic [BEAT_W-1:0] ONE_B = BEAT_W'(1);
  localparam logic [SLOT_W:0]   ONE_S = (SLOT_W+1)'(1);

  logic [BEAT_W-1:0] beat_cnt, beat_idx, def_len;
  logic [SLOT_W:0]   slot_cnt, slot_idx;
  logic              is_beat, is_first, slot_act, is_single, is_incr;

  assign is_beat   = tr_valid & tr_kind[1];
  assign is_first  = tr_valid & (tr_kind == K_NSEQ);
  assign slot_act  = tr_valid & (tr_kind != K_IDLE);
  assign is_single = (burst_kind == 3'd0);
  assign is_incr   = (burst_kind == 3'd1);

  assign beat_idx = is_first ? ONE_B : beat_cnt + ONE_B;
  assign slot_idx = is_first ? ONE_S : (slot_cnt[SLOT_W] ? slot_cnt : slot_cnt + ONE_S);

  always_comb begin
    case (burst_kind[2:1])
      2'b01:   def_len = BEAT_W'(4);
      2'b10:   def_len = BEAT_W'(8);
      2'b11:   def_len = BEAT_W'(16);
      default: def_len = '0;
    endcase
  end

  assign pred_end = is_beat & (is_single
                  | ((def_len != '0) & (beat_idx == def_len))
                  | (is_incr & (undef_mode == 2'd1))
                  | (is_incr & (undef_mode == 2'd2) & (beat_idx[1:0] == 2'b00)));

  assign slot_reached = slot_act & (slot_limit != '0) & (slot_idx == {1'b0, slot_limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      slot_cnt <= '0;
    end else if (tr_valid) begin
      case (tr_kind)
        K_IDLE: begin beat_cnt <= '0;       slot_cnt <= '0;       end
        K_NSEQ: begin beat_cnt <= ONE_B;    slot_cnt <= ONE_S;    end
        K_SEQ:  begin beat_cnt <= beat_idx; slot_cnt <= slot_idx; end
        default:      slot_cnt <= slot_idx;
      endcase
    end
  end

  a_r7_busy_holds_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_kind == K_BUSY) |=> $stable(beat_cnt));
  a_r11_idle_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_valid |=> ($stable(beat_cnt) && $stable(slot_cnt)));
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_kind == K_NSEQ) |=> (beat_cnt == ONE_B && slot_cnt == ONE_S));
  a_r10_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_limit == '0) |-> !slot_reached);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slot_reached ##1 (tr_valid && tr_kind != K_NSEQ) |-> !slot_reached);
  a_r4_unlimited: assert property (@(posedge clk) disable iff (!rst_n)
    (is_incr && (undef_mode == 2'd0 || undef_mode == 2'd3)) |-> !pred_end);
endmodule

// File: tb/burst_end_predictor_tb_top.sv
module burst_end_predictor_tb_top;
  localparam int SW = 8;
  logic clk = 0, rst_n = 0;
  logic tr_valid = 0;
  logic [1:0] tr_kind = 0;
  logic [2:0] burst_kind = 0;
  logic [1:0] undef_mode = 0;
  logic [SW-1:0] slot_limit = 0;
  logic pred_end, slot_reached;
  int checks = 0, bad = 0;
  int m_beat = 0, m_slot = 0;
  string tag_ovr = "";

  always #2.5 clk = ~clk;

  burst_end_predictor #(.SLOT_W(SW), .BEAT_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_kind(tr_kind),
    .burst_kind(burst_kind), .undef_mode(undef_mode), .slot_limit(slot_limit),
    .pred_end(pred_end), .slot_reached(slot_reached));

  function automatic int blen(input logic [2:0] b);
    case (b[2:1]) 2'b01: return 4; 2'b10: return 8; 2'b11: return 16; default: return 0; endcase
  endfunction

  function automatic int bidx();
    return (tr_kind == 2) ? 1 : (m_beat + 1) % 32;
  endfunction

  function automatic int sidx();
    if (tr_kind == 2) return 1;
    return (m_slot >= (1 << SW)) ? m_slot : m_slot + 1;
  endfunction

  function automatic bit exp_end();
    int i;
    if (!(tr_valid && tr_kind[1])) return 0;
    i = bidx();
    if (burst_kind == 0) return 1;
    if (blen(burst_kind) != 0) return i == blen(burst_kind);
    if (undef_mode == 1) return 1;
    if (undef_mode == 2) return (i % 4) == 0;
    return 0;
  endfunction

  function automatic bit exp_slot();
    if (!(tr_valid && tr_kind != 0) || slot_limit == 0) return 0;
    return sidx() == int'(slot_limit);
  endfunction

  function automatic string end_tag();
    if (tag_ovr != "") return tag_ovr;
    if (!tr_valid) return "R11";
    if (tr_kind == 1) return "R7";
    if (tr_kind == 2) return "R8";
    if (burst_kind == 0) return "R2";
    if (blen(burst_kind) != 0) return "R3";
    if (undef_mode == 1) return "R5";
    if (undef_mode == 2) return "R6";
    return "R4";
  endfunction

  function automatic string slot_tag();
    if (tag_ovr != "") return tag_ovr;
    if (!tr_valid) return "R11";
    return (slot_limit == 0) ? "R10" : "R9";
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [2:0] b,
                      input logic [1:0] md, input logic [SW-1:0] lim);
    bit ee, es;
    int ni, ns;
    @(negedge clk);
    tr_valid = v; tr_kind = k; burst_kind = b; undef_mode = md; slot_limit = lim;
    #1;
    ee = exp_end(); es = exp_slot(); ni = bidx(); ns = sidx();
    chk(pred_end, ee, end_tag(), "pred_end");
    chk(slot_reached, es, slot_tag(), "slot_reached");
    @(posedge clk);
    if (v) begin
      case (k)
        2'd0: begin m_beat = 0; m_slot = 0; end
        2'd2: begin m_beat = 1; m_slot = 1; end
        2'd3: begin m_beat = ni; m_slot = ns; end
        default: m_slot = ns;
      endcase
    end
  endtask

  task automatic burst(input logic [2:0] b, input logic [1:0] md, input logic [SW-1:0] lim,
                       input int beats, input int busy_pct, input int gap_pct);
    for (int i = 0; i < beats; i++) begin
      while ($urandom % 100 < gap_pct) step(0, 2'($urandom), b, md, lim);
      while ($urandom % 100 < busy_pct && i > 0) step(1, 1, b, md, lim);
      step(1, (i == 0) ? 2'd2 : 2'd3, b, md, lim);
    end
  endtask

  initial begin
    #900000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1 checks++;
    if (pred_end !== 0 || slot_reached !== 0) begin
      bad++; $display("FAIL R1 reset outputs actual=%0b%0b expected=00", pred_end, slot_reached);
    end
    rst_n = 1;
    // R1: SEQ before any NONSEQ counts from 1
    tag_ovr = "R1";
    for (int i = 0; i < 4; i++) step(1, 3, 3'd1, 2'd2, 8'd3);
    tag_ovr = "";
    step(1, 0, 0, 0, 0);
    // both flags on beat 4 of a 4-beat burst with limit 4
    burst(3'd3, 0, 8'd4, 4, 0, 0);
    burst(3'd1, 2'd2, 8'd4, 8, 0, 0);
    // R4: long unlimited incr burst, no limit
    burst(3'd1, 2'd0, 8'd0, 300, 0, 0);
    // R9: saturation with max limit over long burst
    burst(3'd1, 2'd3, 8'd255, 300, 0, 0);
    // R7: busy between beats of 4-beat split
    burst(3'd1, 2'd2, 8'd0, 12, 50, 0);
    for (int n = 0; n < 400; n++) begin
      logic [2:0] b;
      logic [1:0] md;
      logic [SW-1:0] lim;
      int len;
      b = 3'($urandom);
      md = 2'($urandom);
      lim = ($urandom % 4 == 0) ? 8'd0 : SW'($urandom % 14);
      len = (b == 0) ? 1 : (blen(b) != 0 ? blen(b) : 1 + $urandom % 20);
      if ($urandom % 8 == 0) len = 1 + $urandom % 40;
      burst(b, md, lim, len, 15, 10);
      if ($urandom % 3 == 0) step(1, 0, b, md, lim);
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule